// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Datapath

This block is the arithmetic core of a small 16-bit fixed-point signal processor. Two 16-bit operand registers feed a signed multiplier. The upper 24 bits of each 32-bit product are held in a product register that only the multiplier writes. A 24-bit accumulator captures every result of a small ALU. The ALU can load, add or subtract. Its second operand is either the product or a 16-bit bus word, and a bus word is aligned to the top of the 24-bit word.

Two mode inputs shape the arithmetic. The scale input pre-shifts the product arithmetically right by three bits before the ALU uses it, which leaves headroom for long sums. The saturate input makes an overflowing result clamp to the extreme 24-bit values instead of wrapping. Each ALU operation updates negative, overflow, zero and carry flags. A plain 16-bit transfer moves a bus word into the accumulator, and the upper 16 accumulator bits are always available as a 16-bit read value.

Top module: `mac_datapath`

## Requirements
- R1: A synchronous active-high reset clears X, Y, P, A and all four flags to zero.
- R2: x_we loads dbus into X and y_we loads dbus into Y at the clock edge. Both registers read back on x_q and y_q from the next cycle, and they act as plain storage registers.
- R3: P (p_q) equals bits 31:8 of the signed product of X and Y. It is registered one edge after X and Y hold their values. Writes on dbus never alter it directly.
- R4: acc_we with alu_go low loads A with dbus in bits 23:8 and zeros in bits 7:0. The flags are left unchanged.
- R5: acc_hi always equals A bits 23:8.
- R6: alu_go performs the operation given by alu_op: 0 = load operand, 1 = A + operand, 2 = A − operand. Code 3 leaves A and the flags unchanged. The operand is P when alu_src = 0. It is {dbus, 8'h00} when alu_src = 1. alu_go takes priority over acc_we.
- R7: When scale_en is 1 and alu_src = 0, the operand is P arithmetically shifted right by 3. scale_en has no effect on a bus operand.
- R8: After an add or subtract, flag_v is 1 exactly when the exact signed result lies outside [−2^23, 2^23−1]. This holds whether or not saturation is on. A load clears flag_v.
- R9: When sat_en is 1 and flag_v would be set, A becomes 24'h7FFFFF for a positive exact result and 24'h800000 for a negative one. With sat_en at 0 the result wraps modulo 2^24.
- R10: flag_n equals bit 23 of the value written to A, after clamping, and flag_z is 1 exactly when that value is zero.
- R11: flag_c is the carry out of bit 23 for an unsigned add. For a subtract it is 1 when A is below the operand as unsigned numbers (a borrow). A load clears it.
- R12: With neither alu_go nor acc_we asserted, A and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbus | input | 16 | Shared data word for X, Y, accumulator transfer and bus operand |
| x_we | input | 1 | Write X from dbus |
| y_we | input | 1 | Write Y from dbus |
| acc_we | input | 1 | 16-bit transfer of dbus into the accumulator |
| alu_go | input | 1 | Perform an ALU operation this cycle |
| alu_op | input | 2 | 0 load, 1 add, 2 subtract, 3 no operation |
| alu_src | input | 1 | 0 selects the product, 1 selects the aligned dbus word |
| scale_en | input | 1 | Arithmetic right shift of the product by three |
| sat_en | input | 1 | Clamp on overflow |
| x_q | output | 16 | X register |
| y_q | output | 16 | Y register |
| p_q | output | 24 | Product register |
| acc_q | output | 24 | Accumulator |
| acc_hi | output | 16 | Accumulator bits 23:8 |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
X and Y are due one edge after their write strobe. P is due one edge after the last of X and Y has settled, which is two edges after a Y write. A transfer or ALU result, together with its flags, is due on the edge where the command is sampled. The bench drives every command on a falling edge and releases it after one cycle. It waits on falling edges for exactly these counts before it compares, so each sample falls half a period after the edge that produced the value. Sweeps pair corner operand values against each other under every combination of scale and saturate, with results computed arithmetically at full width.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_NONE = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = 16,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] wdata,
  input  logic          x_we,
  input  logic          y_we,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic [PW-1:0] p_q
);
  localparam int FW = 2 * DW;

  logic signed [FW-1:0] prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      if (x_we) x_q <= wdata;
      if (y_we) y_q <= wdata;
    end
  end

  assign prod = $signed(x_q) * $signed(y_q);

  always_ff @(posedge clk) begin
    if (rst) p_q <= '0;
    else     p_q <= prod[FW-1 -: PW];
  end
endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 24,
  parameter int SHIFT = 3
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] prod,
  input  logic [DW-1:0] bus,
  input  alu_op_e       op,
  input  logic          src_bus,
  input  logic          scale_en,
  input  logic          sat_en,
  output logic [AW-1:0] result,
  output alu_flags_t    flags
);
  localparam int EW = AW + 2;
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] prod_sc, opnd;
  logic [EW-1:0] wa, wb, wsum;
  logic [AW:0]   uadd, usub;
  logic          ovf;

  always_comb begin
    prod_sc = scale_en ? AW'($signed(prod) >>> SHIFT) : prod;
    opnd    = src_bus ? {bus, {(AW-DW){1'b0}}} : prod_sc;
    wa      = {{2{acc[AW-1]}}, acc};
    wb      = {{2{opnd[AW-1]}}, opnd};
    wsum    = (op == OP_SUB) ? (wa - wb) : (wa + wb);
    uadd    = {1'b0, acc} + {1'b0, opnd};
    usub    = {1'b0, acc} - {1'b0, opnd};
    ovf     = (op != OP_LOAD) &&
              !((wsum[EW-1:AW-1] == '0) || (wsum[EW-1:AW-1] == '1));

    if (op == OP_LOAD)      result = opnd;
    else if (ovf && sat_en) result = wsum[EW-1] ? MINV : MAXV;
    else                    result = wsum[AW-1:0];

    flags.n = result[AW-1];
    flags.z = (result == '0);
    flags.v = ovf;
    case (op)
      OP_ADD:  flags.c = uadd[AW];
      OP_SUB:  flags.c = usub[AW];
      default: flags.c = 1'b0;
    endcase
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 24,
  parameter int SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] dbus,
  input  logic          x_we,
  input  logic          y_we,
  input  logic          acc_we,
  input  logic          alu_go,
  input  logic [1:0]    alu_op,
  input  logic          alu_src,
  input  logic          scale_en,
  input  logic          sat_en,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic [AW-1:0] p_q,
  output logic [AW-1:0] acc_q,
  output logic [DW-1:0] acc_hi,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_c
);
  localparam int LOW = AW - DW;

  alu_op_e       op;
  logic [AW-1:0] alu_res;
  alu_flags_t    alu_fl, fl_q;

  assign op = alu_op_e'(alu_op);

  mac_mult #(.DW(DW), .PW(AW)) u_mult (
    .clk(clk), .rst(rst), .wdata(dbus), .x_we(x_we), .y_we(y_we),
    .x_q(x_q), .y_q(y_q), .p_q(p_q)
  );

  mac_alu #(.DW(DW), .AW(AW), .SHIFT(SHIFT)) u_alu (
    .acc(acc_q), .prod(p_q), .bus(dbus), .op(op), .src_bus(alu_src),
    .scale_en(scale_en), .sat_en(sat_en), .result(alu_res), .flags(alu_fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fl_q  <= '0;
    end else if (alu_go) begin
      if (op != OP_NONE) begin
        acc_q <= alu_res;
        fl_q  <= alu_fl;
      end
    end else if (acc_we) begin
      acc_q <= {dbus, {LOW{1'b0}}};
    end
  end

  assign acc_hi = acc_q[AW-1 -: DW];
  assign flag_n = fl_q.n;
  assign flag_v = fl_q.v;
  assign flag_z = fl_q.z;
  assign flag_c = fl_q.c;
endmodule

// File: rtl/mac_datapath_chk.sv
module mac_datapath_chk #(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] dbus,
  input logic          x_we,
  input logic          y_we,
  input logic          acc_we,
  input logic          alu_go,
  input logic [1:0]    alu_op,
  input logic          sat_en,
  input logic [DW-1:0] x_q,
  input logic [DW-1:0] y_q,
  input logic [AW-1:0] p_q,
  input logic [AW-1:0] acc_q,
  input logic          flag_n,
  input logic          flag_v,
  input logic          flag_z,
  input logic          flag_c
);
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  logic signed [2*DW-1:0] ref_prod;
  assign ref_prod = $signed(x_q) * $signed(y_q);

  a_r3_product: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> p_q == $past(ref_prod[2*DW-1 -: AW]));

  a_r4_transfer_align: assert property (@(posedge clk) disable iff (rst)
    (acc_we && !alu_go) |=> (acc_q == {$past(dbus), {(AW-DW){1'b0}}}) && $stable({flag_n, flag_v, flag_z, flag_c}));

  a_r9_clamp: assert property (@(posedge clk) disable iff (rst)
    (alu_go && sat_en && alu_op != 2'd3) |=> (!flag_v || acc_q == MAXV || acc_q == MINV));

  a_r10_nz: assert property (@(posedge clk) disable iff (rst)
    (alu_go && alu_op != 2'd3) |=> (flag_n == acc_q[AW-1]) && (flag_z == (acc_q == '0)));

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (!alu_go && !acc_we) |=> $stable(acc_q) && $stable({flag_n, flag_v, flag_z, flag_c}));

  a_r2_x_hold: assert property (@(posedge clk) disable iff (rst)
    !x_we |=> $stable(x_q));

  a_r2_y_hold: assert property (@(posedge clk) disable iff (rst)
    !y_we |=> $stable(y_q));
endmodule

bind mac_datapath mac_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .dbus(dbus), .x_we(x_we), .y_we(y_we),
  .acc_we(acc_we), .alu_go(alu_go), .alu_op(alu_op), .sat_en(sat_en),
  .x_q(x_q), .y_q(y_q), .p_q(p_q), .acc_q(acc_q),
  .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/mac_datapath_tb.sv
`timescale 1ns/1ps
module mac_datapath_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] dbus = '0;
  logic        x_we = 0, y_we = 0, acc_we = 0, alu_go = 0;
  logic [1:0]  alu_op = '0;
  logic        alu_src = 0, scale_en = 0, sat_en = 0;
  logic [15:0] x_q, y_q, acc_hi;
  logic [23:0] p_q, acc_q;
  logic        flag_n, flag_v, flag_z, flag_c;

  int n_chk = 0, n_bad = 0;
  logic [23:0] e_acc = '0, e_p = '0;
  logic [3:0]  e_fl = '0;

  always #2.5 clk = ~clk;

  mac_datapath u_dut (
    .clk(clk), .rst(rst), .dbus(dbus), .x_we(x_we), .y_we(y_we),
    .acc_we(acc_we), .alu_go(alu_go), .alu_op(alu_op), .alu_src(alu_src),
    .scale_en(scale_en), .sat_en(sat_en), .x_q(x_q), .y_q(y_q), .p_q(p_q),
    .acc_q(acc_q), .acc_hi(acc_hi), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // R3: P = bits 31:8 of the signed product, due two edges after the Y write
  task automatic set_xy(input logic [15:0] xv, input logic [15:0] yv);
    logic signed [31:0] pr;
    dbus = xv; x_we = 1;
    @(negedge clk);
    x_we = 0; dbus = yv; y_we = 1;
    @(negedge clk);
    y_we = 0;
    chk("R2 x/y", {x_q, y_q}, {xv, yv});
    @(negedge clk);
    pr = $signed(xv) * $signed(yv);
    e_p = pr[31:8];
    chk("R3 product", {8'h0, p_q}, {8'h0, e_p});
  endtask

  task automatic xfer(input logic [15:0] v);
    dbus = v; acc_we = 1;
    @(negedge clk);
    acc_we = 0;
    e_acc = {v, 8'h00};
    chk("R4 transfer", {8'h0, acc_q}, {8'h0, e_acc});
    chk("R4 flags kept", {28'h0, flag_n, flag_v, flag_z, flag_c}, {28'h0, e_fl});
    chk("R5 acc_hi", {16'h0, acc_hi}, {16'h0, v});
  endtask

  task automatic alu(input string tag, input logic [1:0] op, input logic src,
                     input logic [15:0] bv, input logic sc, input logic st);
    logic [23:0] b, r;
    logic signed [25:0] s;
    logic v, c;
    b = src ? {bv, 8'h00} : (sc ? 24'($signed(e_p) >>> 3) : e_p);
    s = (op == 2'd2) ? ($signed({{2{e_acc[23]}}, e_acc}) - $signed({{2{b[23]}}, b}))
                     : ($signed({{2{e_acc[23]}}, e_acc}) + $signed({{2{b[23]}}, b}));
    v = (op != 2'd0) && (s > 26'sd8388607 || s < -26'sd8388608);
    c = (op == 2'd1) ? ((25'(e_acc) + 25'(b)) >> 24) != 0 :
        (op == 2'd2) ? (e_acc < b) : 1'b0;
    if (op == 2'd0) r = b;
    else if (v && st) r = s[25] ? 24'h800000 : 24'h7FFFFF;
    else r = s[23:0];
    dbus = bv; alu_op = op; alu_src = src; scale_en = sc; sat_en = st; alu_go = 1;
    @(negedge clk);
    alu_go = 0;
    if (op != 2'd3) begin
      e_acc = r;
      e_fl = {r[23], v, r == 24'h0, c};
    end
    chk(tag, {4'h0, flag_n, flag_v, flag_z, flag_c, acc_q}, {4'h0, e_fl, e_acc});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'hEDCC, 16'h0100};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset", {x_q, y_q}, 32'h0);
    chk("R1 reset p/acc", {p_q, 8'h0} | {8'h0, acc_q}, 32'h0);
    chk("R1 reset flags", {28'h0, flag_n, flag_v, flag_z, flag_c}, 32'h0);
    rst = 0;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        set_xy(vals[i], vals[j]);
        // R6 R7 R8 R9 R11: add and subtract of P under scale/saturate combos
        xfer(16'h7000);
        alu("R6 R8 R9 R11 add P", 2'd1, 1'b0, 16'h0, 1'(i), 1'(j));
        xfer(16'h9000);
        alu("R6 R8 R9 R11 sub P", 2'd2, 1'b0, 16'h0, 1'(j >> 1), 1'(i ^ j));
        alu("R7 load P", 2'd0, 1'b0, 16'h0, 1'(i >> 1), 1'b0);
        alu("R10 add P again", 2'd1, 1'b0, 16'h0, 1'b0, 1'(j >> 2));
      end
    end

    // R9: wrap vs clamp on bus operand, both directions
    xfer(16'h7FFF);
    alu("R9 wrap positive", 2'd1, 1'b1, 16'h0001, 1'b0, 1'b0);
    chk("R9 wrapped value", {8'h0, acc_q}, 32'h00800000);
    xfer(16'h7FFF);
    alu("R9 clamp positive", 2'd1, 1'b1, 16'h0001, 1'b0, 1'b1);
    chk("R9 clamped max", {8'h0, acc_q}, 32'h007FFFFF);
    xfer(16'h8000);
    alu("R9 clamp negative", 2'd2, 1'b1, 16'h0001, 1'b0, 1'b1);
    chk("R9 clamped min", {8'h0, acc_q}, 32'h00800000);
    // R7: scale has no effect on bus operand
    xfer(16'h0000);
    alu("R7 bus not scaled", 2'd0, 1'b1, 16'h0800, 1'b1, 1'b0);
    chk("R7 bus value", {8'h0, acc_q}, 32'h00080000);
    // R10: zero result
    alu("R10 zero", 2'd2, 1'b1, 16'h0800, 1'b0, 1'b0);
    chk("R10 z flag", {31'h0, flag_z}, 32'h1);
    // R11: borrow on subtract
    alu("R11 borrow", 2'd2, 1'b1, 16'h0001, 1'b0, 1'b0);
    chk("R11 c flag", {31'h0, flag_c}, 32'h1);
    // R6: code 3 is a no-op
    alu("R6 op3 no effect", 2'd3, 1'b1, 16'h1234, 1'b0, 1'b0);
    // R6: alu_go has priority over acc_we
    acc_we = 1;
    alu("R6 go beats transfer", 2'd0, 1'b1, 16'h4321, 1'b0, 1'b0);
    acc_we = 0;
    // R12: idle cycles hold A and flags
    dbus = 16'hBEEF;
    repeat (3) @(negedge clk);
    chk("R12 hold", {4'h0, flag_n, flag_v, flag_z, flag_c, acc_q}, {4'h0, e_fl, e_acc});
    chk("R3 P not written by bus", {8'h0, p_q}, {8'h0, e_p});
    summary();
  end
endmodule